// File: doc/BRIEF.md
# Oversampled UART Receive Data Recovery

This block recovers characters from an asynchronous serial receive line. It is driven by a clock enable that pulses at sixteen times the baud rate. Between characters it watches the line for a low sample that comes right after three high samples. That sample becomes tick 1 of a sixteen-tick bit timer. Three samples of the start bit then either confirm it or send the block back to its search. Each following data bit, and the stop bit, is decided by a majority vote over three samples taken in the middle of the bit.

Senders whose bit rate is slightly off are tracked by moving the bit timer. When a bit that resolves high is followed by a bit that resolves low, the timer is re-anchored on the falling edge between them. A smart-card sampling mode moves the start-bit check to the middle of the bit. The frame length is eight or nine data bits. The byte is presented with a one-cycle valid strobe, and a noise flag and a framing-error flag ride on that strobe.

Top module: `uart_rx_recovery`

## Requirements
- R1: During reset and right after it, `data_valid`, `noise_flag` and `frame_err` are 0. The high-sample history is cleared, so three sampled 1s must come before any start edge is accepted.
- R2: Only cycles with `os_tick` high are sampling ticks. In the search state, a tick that samples `rxd`=0 when the three previous ticks sampled 1 is taken as tick 1 of the start bit.
- R3: With `card_mode`=0, the start bit is checked with the samples at ticks 3, 5 and 7. If none or one of them is 1, the start bit is accepted, and exactly one 1 marks the character as noisy. If two or more are 1, the start bit is rejected.
- R4: With `card_mode`=1, the same start-bit check uses the samples at ticks 8, 9 and 10 instead.
- R5: A rejected start bit returns the block to the search with the history cleared. No character is delivered, and a later valid frame is received normally.
- R6: Each data bit is the majority of the samples at ticks 8, 9 and 10 of its bit period. Bits arrive LSB first, and the first data bit lands in `data_out[0]`. With `nine_bits`=0 a frame has 8 data bits and `data_out[8]` reads 0.
- R7: With `nine_bits`=1 a frame has 9 data bits, and the ninth lands in `data_out[8]`. The frame length is taken when the start edge is seen.
- R8: If the three samples of the start bit, of any data bit or of the stop bit are not all equal, `noise_flag` is 1 in the cycle of `data_valid`. The data is still the majority result.
- R9: A stop bit whose majority is 0 sets `frame_err` together with `data_valid`, and the data is still delivered.
- R10: When a data bit resolves to 1 and the next bit resolves to 0, the bit timer is realigned so that the first 0 sample after the earlier bit's decision counts as tick 1. A sender whose 1 bits last 22 ticks and whose 0 bits last 16 ticks is then received without error.
- R11: `data_valid` is a one-cycle pulse. It rises at the clock edge of the stop bit's tick 10, which is 16*(N+1)+10 ticks after the tick that samples the start edge, where N is the number of data bits. `noise_flag` and `frame_err` are never 1 without `data_valid`.
- R12: Cycles with `os_tick`=0 change nothing: the line may toggle freely and no character results. A frame sent with a tick every second clock is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sampling enable at 16x the baud rate |
| rxd | input | 1 | Receive line, already synchronous to clk |
| card_mode | input | 1 | 1 = check the start bit at mid-bit ticks 8/9/10 |
| nine_bits | input | 1 | 1 = nine data bits, 0 = eight |
| data_out | output | 9 | Received character, LSB = first bit |
| data_valid | output | 1 | One-cycle strobe for a finished character |
| noise_flag | output | 1 | Sample disagreement in this character |
| frame_err | output | 1 | Stop bit resolved to 0 |

## Verification
A character's result is registered at the stop bit's tick 10. When there is a tick every clock, the strobe therefore shows up 16*(N+1)+10 clocks after the clock that samples the start edge. The bench records the cycle count when it launches each frame and compares it with the cycle in which it sees the strobe. Outputs are captured on the falling clock edge, half a cycle after the register updates, and the flags are read in that same cycle. Outcomes where no character should appear are checked by watching the strobe count across a full frame plus idle time, and then sending a clean frame to show that the search has resumed.

// File: rtl/uart_rx_recovery.sv
module uart_rx_recovery #(
  parameter int OSR     = 16,
  parameter int MAXBITS = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               os_tick,
  input  logic               rxd,
  input  logic               card_mode,
  input  logic               nine_bits,
  output logic [MAXBITS-1:0] data_out,
  output logic               data_valid,
  output logic               noise_flag,
  output logic               frame_err
);
  localparam int CW = $clog2(OSR + 1);
  localparam int BW = $clog2(MAXBITS + 2);
  localparam logic [CW-1:0] FIRST = CW'(1);
  localparam logic [CW-1:0] LAST  = CW'(OSR);
  localparam logic [CW-1:0] MIDA  = CW'(OSR / 2);
  localparam logic [CW-1:0] MIDB  = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] MIDC  = CW'(OSR / 2 + 2);
  localparam logic [CW-1:0] ERA   = CW'(3 * OSR / 16);
  localparam logic [CW-1:0] ERB   = CW'(5 * OSR / 16);
  localparam logic [CW-1:0] ERC   = CW'(7 * OSR / 16);
  localparam logic [CW:0]   OSR_W = (CW + 1)'(OSR);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [2:0]        hist;
  logic [1:0]        smp;
  logic [MAXBITS-1:0] sh;
  logic [BW-1:0]     idx;
  logic              nine_q, noisy, prev_one, edge_seen, done_bit;
  logic [CW:0]       since;

  logic [CW-1:0] cur, pa, pb, pc;
  logic [1:0]    ones;
  logic          maj, split;
  logic [BW-1:0] nbits;

  assign cur   = (cnt == LAST) ? FIRST : cnt + FIRST;
  assign pa    = card_mode ? MIDA : ERA;
  assign pb    = card_mode ? MIDB : ERB;
  assign pc    = card_mode ? MIDC : ERC;
  assign ones  = {1'b0, smp[1]} + {1'b0, smp[0]} + {1'b0, rxd};
  assign maj   = ones[1];
  assign split = (ones == 2'd1) || (ones == 2'd2);
  assign nbits = nine_q ? BW'(MAXBITS) : BW'(MAXBITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      hist       <= '0;
      smp        <= '0;
      sh         <= '0;
      idx        <= '0;
      nine_q     <= 1'b0;
      noisy      <= 1'b0;
      prev_one   <= 1'b0;
      edge_seen  <= 1'b0;
      done_bit   <= 1'b0;
      since      <= '0;
      data_out   <= '0;
      data_valid <= 1'b0;
      noise_flag <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      noise_flag <= 1'b0;
      frame_err  <= 1'b0;
      if (os_tick) begin
        case (st)
          S_IDLE: begin
            if (!rxd && hist == 3'b111) begin
              st     <= S_START;
              cnt    <= FIRST;
              hist   <= '0;
              noisy  <= 1'b0;
              nine_q <= nine_bits;
            end else begin
              hist <= {hist[1:0], rxd};
            end
          end
          S_START: begin
            cnt <= cur;
            if (cur == pa) smp[1] <= rxd;
            if (cur == pb) smp[0] <= rxd;
            if (cur == pc) begin
              if (maj) begin
                st   <= S_IDLE;
                hist <= '0;
              end else begin
                noisy <= split;
              end
            end
            if (cur == LAST) begin
              st        <= S_DATA;
              idx       <= '0;
              prev_one  <= 1'b0;
              edge_seen <= 1'b0;
              done_bit  <= 1'b0;
            end
          end
          S_DATA: begin
            cnt <= cur;
            if (cur == FIRST) done_bit <= 1'b0;
            if (cur == MIDA) smp[1] <= rxd;
            if (cur == MIDB) smp[0] <= rxd;
            if (!edge_seen && !rxd) begin
              edge_seen <= 1'b1;
              since     <= (CW + 1)'(1);
            end else if (since != '1) begin
              since <= since + 1'b1;
            end
            if (cur == MIDC && !done_bit) begin
              done_bit  <= 1'b1;
              edge_seen <= 1'b0;
              prev_one  <= maj;
              noisy     <= noisy | split;
              if (prev_one && edge_seen && !maj && since < OSR_W)
                cnt <= since[CW-1:0] + FIRST;
              if (idx == nbits) begin
                data_valid <= 1'b1;
                frame_err  <= ~maj;
                noise_flag <= noisy | split;
                data_out   <= nine_q ? sh : (sh >> 1);
                hist       <= {smp, rxd};
                st         <= S_IDLE;
              end else begin
                sh  <= {maj, sh[MAXBITS-1:1]};
                idx <= idx + 1'b1;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_recovery_chk.sv
module uart_rx_recovery_chk (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic data_valid,
  input logic noise_flag,
  input logic frame_err
);
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
  p_noise_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    noise_flag |-> data_valid);
  p_ferr_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> data_valid);
  p_valid_after_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(os_tick));
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !data_valid);
endmodule

bind uart_rx_recovery uart_rx_recovery_chk u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
  .data_valid(data_valid), .noise_flag(noise_flag), .frame_err(frame_err)
);

// File: tb/uart_rx_recovery_bench.sv
`timescale 1ns/1ps
module uart_rx_recovery_bench;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b1, rxd = 1'b1;
  logic card_mode = 1'b0, nine_bits = 1'b0;
  logic [8:0] data_out;
  logic data_valid, noise_flag, frame_err;

  always #2 clk = ~clk;

  uart_rx_recovery u_uart_rx_recovery (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .card_mode(card_mode), .nine_bits(nine_bits), .data_out(data_out),
    .data_valid(data_valid), .noise_flag(noise_flag), .frame_err(frame_err)
  );

  int total = 0, bad = 0, div = 1, cyc = 0, nval = 0, vcyc = 0;
  logic [8:0] cap_d;
  logic cap_n, cap_f, finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && data_valid) begin
    nval  <= nval + 1;
    cap_d <= data_out; cap_n <= noise_flag; cap_f <= frame_err; vcyc <= cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      os_tick = 1'b1; @(negedge clk);
      for (int j = 1; j < div; j++) begin os_tick = 1'b0; @(negedge clk); end
    end
    os_tick = 1'b1;
  endtask

  task automatic send(input logic [8:0] d, input int nb, input logic stopv,
                      input int gbit, input int gt1, input int gt2);
    for (int b = 0; b <= nb + 1; b++)
      for (int t = 1; t <= 16; t++) begin
        logic v;
        v = (b == 0) ? 1'b0 : (b == nb + 1) ? stopv : d[b-1];
        if (b == gbit && (t == gt1 || t == gt2)) v = ~v;
        rxd = v; tk(1);
      end
    rxd = 1'b1;
  endtask

  task automatic idle(input int n); rxd = 1'b1; tk(n); @(negedge clk); endtask

  localparam logic [10:0] VEC [8] = '{
    {1'b0, 1'b0, 9'h0A5}, {1'b0, 1'b0, 9'h000}, {1'b0, 1'b0, 9'h0FF},
    {1'b0, 1'b1, 9'h03C}, {1'b1, 1'b0, 9'h1A5}, {1'b1, 1'b1, 9'h155},
    {1'b1, 1'b0, 9'h100}, {1'b0, 1'b0, 9'h181}
  };

  initial begin
    int n0, k, nb;
    logic [8:0] expd;
    repeat (4) @(negedge clk);
    chk(data_valid == 0 && noise_flag == 0 && frame_err == 0, "R1 reset outputs",
        data_valid + noise_flag + frame_err, 0);
    rst_n = 1'b1;
    // R1: only two 1s before a low line: no start accepted
    n0 = nval;
    rxd = 1'b1; tk(2); rxd = 1'b0; tk(20); idle(200);
    chk(nval == n0, "R1 history cleared by reset", nval - n0, 0);

    foreach (VEC[i]) begin
      nine_bits = VEC[i][10]; card_mode = VEC[i][9];
      nb = nine_bits ? 9 : 8;
      expd = nine_bits ? VEC[i][8:0] : {1'b0, VEC[i][7:0]};
      n0 = nval; k = cyc;
      send(VEC[i][8:0], nb, 1'b1, -1, 0, 0);
      idle(4);
      chk(nval == n0 + 1, "R6 one character", nval - n0, 1);
      chk(cap_d == expd, nine_bits ? "R7 nine-bit data" : "R6 eight-bit data", cap_d, expd);
      chk(cap_n == 0 && cap_f == 0, "R8 clean flags", {cap_n, cap_f}, 0);
      chk(vcyc == k + 16 * (nb + 1) + 10, "R11 strobe timing R2", vcyc - k, 16 * (nb + 1) + 10);
    end
    nine_bits = 1'b0;

    // R3: normal mode, one 1 at tick 5 -> noisy pass
    card_mode = 1'b0; n0 = nval;
    send(9'h0C3, 8, 1'b1, 0, 5, 0); idle(4);
    chk(nval == n0 + 1 && cap_d == 9'h0C3, "R3 single 1 passes", cap_d, 9'h0C3);
    chk(cap_n == 1, "R3 noise on start", cap_n, 1);
    // R3: ticks 9,10 high in normal mode are not looked at
    n0 = nval;
    send(9'h03C, 8, 1'b1, 0, 9, 10); idle(4);
    chk(nval == n0 + 1 && cap_n == 0, "R3 uses ticks 3/5/7", cap_n, 0);
    // R3/R5: two 1s (ticks 5,7) reject
    n0 = nval;
    send(9'h1FF, 8, 1'b1, 0, 5, 7); idle(40);
    chk(nval == n0, "R3 R5 reject normal", nval - n0, 0);
    send(9'h012, 8, 1'b1, -1, 0, 0); idle(4);
    chk(nval == n0 + 1 && cap_d == 9'h012, "R5 search resumes", cap_d, 9'h012);
    // R4: card mode
    card_mode = 1'b1; n0 = nval;
    send(9'h099, 8, 1'b1, 0, 9, 0); idle(4);
    chk(nval == n0 + 1 && cap_n == 1, "R4 card noise at tick 9", cap_n, 1);
    n0 = nval;
    send(9'h1FF, 8, 1'b1, 0, 9, 10); idle(40);
    chk(nval == n0, "R4 card reject ticks 9/10", nval - n0, 0);
    n0 = nval;
    send(9'h066, 8, 1'b1, 0, 5, 7); idle(4);
    chk(nval == n0 + 1 && cap_n == 0 && cap_d == 9'h066, "R4 card ignores ticks 5/7", cap_d, 9'h066);
    card_mode = 1'b0;
    // R8: data glitch at tick 9 of bit index 3
    n0 = nval;
    send(9'h0F0, 8, 1'b1, 4, 9, 0); idle(4);
    chk(nval == n0 + 1 && cap_d == 9'h0F0, "R8 majority data", cap_d, 9'h0F0);
    chk(cap_n == 1, "R8 data noise", cap_n, 1);
    // R9: stop bit low
    n0 = nval;
    send(9'h05A, 8, 1'b0, -1, 0, 0); idle(8);
    chk(nval == n0 + 1 && cap_d == 9'h05A, "R9 data kept", cap_d, 9'h05A);
    chk(cap_f == 1, "R9 framing error", cap_f, 1);
    // R10: 1 bits stretched to 22 ticks
    n0 = nval;
    rxd = 1'b0; tk(16);
    for (int b = 0; b < 8; b++) begin rxd = b[0] ? 1'b0 : 1'b1; tk(b[0] ? 16 : 22); end
    rxd = 1'b1; tk(16); idle(8);
    chk(nval == n0 + 1 && cap_d == 9'h055, "R10 resync data", cap_d, 9'h055);
    chk(cap_n == 0 && cap_f == 0, "R10 resync clean", {cap_n, cap_f}, 0);
    // R12: no ticks, toggling line
    n0 = nval; os_tick = 1'b0;
    for (int i = 0; i < 200; i++) begin rxd = i[2]; @(negedge clk); end
    rxd = 1'b1; @(negedge clk);
    chk(nval == n0, "R12 no tick no change", nval - n0, 0);
    idle(4);
    div = 2; n0 = nval;
    send(9'h0B4, 8, 1'b1, -1, 0, 0); idle(4);
    chk(nval == n0 + 1 && cap_d == 9'h0B4, "R12 half-rate ticks", cap_d, 9'h0B4);
    div = 1;

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule